// File: doc/BRIEF.md
# Continuous Burst Read Sequencer

This block sits on the device side of a burst-capable memory. It produces the read addresses and the delivery strobe for a stream of 16-bit words. A host selects the device with an active-low chip enable. It then pulses an active-low address-valid strobe together with a start address. After a programmable initial latency, the sequencer steps through consecutive addresses and delivers one word per clock. The address space is 2^ADDR_W words. Banks are 2^BANK_W words each, and the upper address bits select the bank. Lines are 2^LINE_W words each. The burst runs until chip enable is released, reset is asserted, or a new address-valid pulse starts a fresh burst.

Two events interrupt the stream.
- When the next address starts a new line, the sequencer inserts PEN_CYC dead cycles before data resumes.
- When the next address lies in a different bank whose busy flag is set, the sequencer stops stepping and selects status data in place of array data. It stays in that state until the host releases chip enable or restarts with a new address.

The outgoing stream is valid-only and has no ready signal. A consumer cannot apply back-pressure, so it must take every word in the cycle that `word_valid` is high. The array is a synchronous memory outside this block, addressed by `rd_addr`.

Top module: `burst_read_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `word_valid` = 0, `stat_sel` = 0 and `rd_addr` = 0.
- R2: The latency code `lat_code` gives L = `lat_code` for codes 2 to 7. Codes 0 and 1 give L = 2. The edge that latches the address is edge 0. The first `word_valid` appears in the cycle after edge L, with `rd_addr` equal to the latched address.
- R3: While streaming, each word follows the previous one at `rd_addr`+1, with one word per clock.
- R4: After address 2^ADDR_W-1, the next address is 0. This step is a line and bank crossing into bank 0.
- R5: When the next address has its low LINE_W bits all zero and does not enter a busy bank, `word_valid` is 0 for PEN_CYC cycles. During those cycles `rd_addr` already shows the new address. Streaming then resumes at that address.
- R6: The bank index of an address is its upper ADDR_W-BANK_W bits, and `bank_busy` bit i is the flag for bank i. When the next address is in a different bank whose flag is 1, `stat_sel` goes to 1 and `word_valid` to 0. `rd_addr` then holds that next address. This state persists even if the flag clears, until `ce_n` goes high or a new address is latched.
- R7: While `ce_n` is high, `word_valid` and `stat_sel` are 0 in that same cycle. After `ce_n` returns low, no word is delivered until a new address is latched.
- R8: `adv_n` low with `ce_n` low at a clock edge aborts any burst or status state and latches `start_addr`. The full initial latency of R2 applies again.
- R9: `adv_n` low while `ce_n` is high has no effect. No address is latched and no burst starts.
- R10: Reset is asynchronous. Pulling `rst_n` low mid-burst clears `word_valid` and sets `rd_addr` to 0 at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Chip enable, active low |
| adv_n | input | 1 | Address-valid strobe, active low |
| start_addr | input | ADDR_W | Burst start address, latched with adv_n |
| lat_code | input | 3 | Initial latency setting |
| bank_busy | input | 2^(ADDR_W-BANK_W) | Per-bank busy flags |
| rd_addr | output | ADDR_W | Array read address |
| word_valid | output | 1 | The array word at rd_addr is delivered this cycle |
| stat_sel | output | 1 | Select status data instead of array data |

## Verification
Two functions can fall in the same cycle: the line-crossing penalty and the busy-bank freeze. Both are triggered by one step, and the busy bank must win. The bench provokes this by starting a burst two words before a bank edge, with the target bank flagged. It checks that `stat_sel` rises with no penalty cycle in front, and that clearing the flag afterwards does not release the freeze. It also checks the wrap from the top address into a busy bank 0, where the wrap, the line crossing and the bank crossing all coincide.

// File: rtl/bsq_pkg.sv
package bsq_pkg;

  localparam int LAT_MIN = 2;
  localparam int LAT_MAX = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LAT,
    ST_RUN,
    ST_GAP,
    ST_STAT
  } seq_state_e;

  // Latency codes below the minimum are raised to the minimum.
  function automatic logic [2:0] lat_of(input logic [2:0] code);
    return (code < 3'(LAT_MIN)) ? 3'(LAT_MIN) : code;
  endfunction

endpackage

// File: rtl/bsq_wait_ctr.sv
module bsq_wait_ctr #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          count,
  output logic          expire
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (load)  cnt_q <= load_val;
    else if (count) cnt_q <= cnt_q - 1'b1;
  end

  assign expire = (cnt_q == CW'(1));

endmodule

// File: rtl/bsq_addr_ctr.sv
module bsq_addr_ctr #(
  parameter int ADDR_W = 10,
  parameter int LINE_W = 7,
  parameter int BANK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] next_addr,
  output logic              line_cross,
  output logic              bank_cross
);

  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     addr_q <= '0;
    else if (load)  addr_q <= load_addr;
    else if (step)  addr_q <= next_addr;
  end

  // Natural overflow wraps the top address to zero.
  assign next_addr  = addr_q + ADDR_W'(1);
  assign line_cross = (next_addr[LINE_W-1:0] == '0);
  assign bank_cross = (next_addr[ADDR_W-1:BANK_W] != addr_q[ADDR_W-1:BANK_W]);
  assign addr       = addr_q;

endmodule

// File: rtl/bsq_bank_sel.sv
module bsq_bank_sel #(
  parameter int BIDX_W = 2
) (
  input  logic [(1<<BIDX_W)-1:0] busy,
  input  logic [BIDX_W-1:0]      idx,
  output logic                   hit
);

  localparam int NB = 1 << BIDX_W;

  logic [NB-1:0] match;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    assign match[b] = busy[b] && (idx == BIDX_W'(b));
  end

  assign hit = |match;

endmodule

// File: rtl/burst_read_seq.sv
module burst_read_seq
  import bsq_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int LINE_W  = 7,
  parameter int BANK_W  = 8,
  parameter int PEN_CYC = 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            ce_n,
  input  logic                            adv_n,
  input  logic [ADDR_W-1:0]               start_addr,
  input  logic [2:0]                      lat_code,
  input  logic [(1<<(ADDR_W-BANK_W))-1:0] bank_busy,
  output logic [ADDR_W-1:0]               rd_addr,
  output logic                            word_valid,
  output logic                            stat_sel
);

  localparam int BIDX_W = ADDR_W - BANK_W;
  localparam int CMAX   = (PEN_CYC > LAT_MAX) ? PEN_CYC : LAT_MAX;
  localparam int CW     = $clog2(CMAX + 1);

  seq_state_e        st_q, st_d;
  logic              ld_addr, step;
  logic              t_load, t_count, t_expire;
  logic [CW-1:0]     t_val;
  logic [ADDR_W-1:0] addr, next_addr;
  logic              line_cross, bank_cross, next_busy;

  bsq_addr_ctr #(
    .ADDR_W(ADDR_W), .LINE_W(LINE_W), .BANK_W(BANK_W)
  ) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ld_addr),
    .load_addr (start_addr),
    .step      (step),
    .addr      (addr),
    .next_addr (next_addr),
    .line_cross(line_cross),
    .bank_cross(bank_cross)
  );

  bsq_bank_sel #(.BIDX_W(BIDX_W)) u_bank (
    .busy(bank_busy),
    .idx (next_addr[ADDR_W-1:BANK_W]),
    .hit (next_busy)
  );

  bsq_wait_ctr #(.CW(CW)) u_wait (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (t_load),
    .load_val(t_val),
    .count   (t_count),
    .expire  (t_expire)
  );

  // Priority: chip enable release, then address latch, then state progress.
  always_comb begin
    st_d    = st_q;
    ld_addr = 1'b0;
    step    = 1'b0;
    t_load  = 1'b0;
    t_val   = '0;
    t_count = 1'b0;
    if (ce_n) begin
      st_d = ST_IDLE;
    end else if (!adv_n) begin
      st_d    = ST_LAT;
      ld_addr = 1'b1;
      t_load  = 1'b1;
      t_val   = CW'(lat_of(lat_code));
    end else begin
      case (st_q)
        ST_LAT: begin
          if (t_expire) st_d = ST_RUN;
          else          t_count = 1'b1;
        end
        ST_RUN: begin
          step = 1'b1;
          if (bank_cross && next_busy) begin
            st_d = ST_STAT;
          end else if (line_cross && (PEN_CYC > 0)) begin
            st_d   = ST_GAP;
            t_load = 1'b1;
            t_val  = CW'(PEN_CYC);
          end
        end
        ST_GAP: begin
          if (t_expire) st_d = ST_RUN;
          else          t_count = 1'b1;
        end
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign rd_addr    = addr;
  assign word_valid = (st_q == ST_RUN)  && !ce_n;
  assign stat_sel   = (st_q == ST_STAT) && !ce_n;

endmodule

// File: rtl/bsq_chk.sv
module bsq_chk #(
  parameter int ADDR_W  = 10,
  parameter int LINE_W  = 7,
  parameter int PEN_CYC = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              adv_n,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              word_valid,
  input logic              stat_sel
);

  // R6
  excl_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(word_valid && stat_sel));

  // R7
  ce_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> (!word_valid && !stat_sel));

  // R2
  lat_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !adv_n) |=> !word_valid ##1 !word_valid);

  // R3
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && $past(word_valid)) |-> (rd_addr == $past(rd_addr) + ADDR_W'(1)));

  // R6
  stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_sel && $past(stat_sel)) |-> $stable(rd_addr));

  if (PEN_CYC > 0) begin : g_gap
    // R5
    line_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (word_valid && $past(word_valid)) |-> (rd_addr[LINE_W-1:0] != '0));
  end

endmodule

bind burst_read_seq bsq_chk #(
  .ADDR_W(ADDR_W), .LINE_W(LINE_W), .PEN_CYC(PEN_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ce_n      (ce_n),
  .adv_n     (adv_n),
  .rd_addr   (rd_addr),
  .word_valid(word_valid),
  .stat_sel  (stat_sel)
);

// File: tb/test_burst_read_seq.sv
module test_burst_read_seq;

  localparam int ADDR_W = 10;
  localparam int NB     = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ce_n = 1'b1;
  logic              adv_n = 1'b1;
  logic [ADDR_W-1:0] start_addr = '0;
  logic [2:0]        lat_code = 3'd2;
  logic [NB-1:0]     bank_busy = '0;
  logic [ADDR_W-1:0] rd_addr;
  logic              word_valid;
  logic              stat_sel;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  burst_read_seq i_burst_read_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .adv_n     (adv_n),
    .start_addr(start_addr),
    .lat_code  (lat_code),
    .bank_busy (bank_busy),
    .rd_addr   (rd_addr),
    .word_valid(word_valid),
    .stat_sel  (stat_sel)
  );

  // {lat_code, start address, expected latency}
  localparam logic [16:0] VEC [6] = '{
    {3'd0, 10'd10,  4'd2},
    {3'd1, 10'd40,  4'd2},
    {3'd2, 10'd300, 4'd2},
    {3'd4, 10'd520, 4'd4},
    {3'd5, 10'd777, 4'd5},
    {3'd7, 10'd900, 4'd7}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic start_burst(input int a, input int code);
    ce_n = 1'b0; adv_n = 1'b0;
    start_addr = ADDR_W'(a); lat_code = 3'(code);
    tick();
    adv_n = 1'b1;
  endtask

  task automatic wait_valid(output int n);
    n = 0;
    while (!word_valid && n < 20) begin
      tick();
      n++;
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n;
    logic [ADDR_W-1:0] held;
    tick(); tick();
    check("R1 valid in reset", word_valid, 0);
    check("R1 status in reset", stat_sel, 0);
    check("R1 addr in reset", rd_addr, 0);
    rst_n = 1'b1;
    tick();
    check("R1 valid after reset", word_valid, 0);

    // Table walk: latency per code and sequential stepping; each new
    // vector also aborts the previous burst (R8).
    for (int i = 0; i < 6; i++) begin
      start_burst(int'(VEC[i][13:4]), int'(VEC[i][16:14]));
      wait_valid(n);
      check("R2 latency", n, int'(VEC[i][3:0]));
      check("R2 first addr", rd_addr, int'(VEC[i][13:4]));
      for (int k = 1; k <= 3; k++) begin
        tick();
        check("R3 next valid", word_valid, 1);
        check("R3 next addr", rd_addr, int'(VEC[i][13:4]) + k);
      end
    end

    // R5: line crossing inside bank 0
    start_burst(125, 2);
    wait_valid(n);
    tick(); tick();
    check("R5 last of line", rd_addr, 127);
    tick();
    check("R5 gap valid", word_valid, 0);
    check("R5 gap addr", rd_addr, 128);
    tick();
    check("R5 resume valid", word_valid, 1);
    check("R5 resume addr", rd_addr, 128);

    // R5: bank crossing into a free bank takes the line penalty only
    start_burst(254, 2);
    wait_valid(n);
    tick(); tick();
    check("R5 bank gap valid", word_valid, 0);
    check("R5 bank gap status", stat_sel, 0);
    tick();
    check("R5 bank resume addr", rd_addr, 256);

    // R6: crossing into busy bank 1 beats the line penalty
    bank_busy = 4'b0010;
    start_burst(254, 2);
    wait_valid(n);
    tick(); tick();
    check("R6 status on", stat_sel, 1);
    check("R6 no data", word_valid, 0);
    check("R6 held addr", rd_addr, 256);
    bank_busy = '0;
    tick(); tick(); tick();
    check("R6 status persists", stat_sel, 1);
    check("R6 addr persists", rd_addr, 256);
    start_burst(600, 3);
    check("R8 restart from status", stat_sel, 0);
    wait_valid(n);
    check("R8 restart latency", n, 3);
    check("R8 restart addr", rd_addr, 600);

    // R4: wrap into a free bank 0
    start_burst(1022, 2);
    wait_valid(n);
    tick(); tick();
    check("R4 wrap gap addr", rd_addr, 0);
    tick();
    check("R4 wrap resume valid", word_valid, 1);
    check("R4 wrap resume addr", rd_addr, 0);

    // R4/R6: wrap into busy bank 0
    bank_busy = 4'b0001;
    start_burst(1022, 2);
    wait_valid(n);
    tick(); tick();
    check("R4 wrap busy status", stat_sel, 1);
    check("R4 wrap busy addr", rd_addr, 0);
    bank_busy = '0;

    // R8: abort mid-stream
    start_burst(400, 2);
    wait_valid(n);
    tick();
    start_burst(450, 6);
    wait_valid(n);
    check("R8 abort latency", n, 6);
    check("R8 abort addr", rd_addr, 450);

    // R7: chip enable release
    start_burst(50, 2);
    wait_valid(n);
    ce_n = 1'b1;
    #1;
    check("R7 valid drops", word_valid, 0);
    tick();
    ce_n = 1'b0;
    for (int k = 0; k < 6; k++) begin
      tick();
      check("R7 no words after reselect", word_valid, 0);
    end

    // R9: address strobe ignored while deselected
    held = rd_addr;
    ce_n = 1'b1; adv_n = 1'b0; start_addr = 10'd700; lat_code = 3'd2;
    tick();
    adv_n = 1'b1; ce_n = 1'b0;
    for (int k = 0; k < 8; k++) tick();
    check("R9 no burst", word_valid, 0);
    check("R9 addr unchanged", rd_addr, held);

    // R10: asynchronous reset mid-burst
    start_burst(60, 2);
    wait_valid(n);
    rst_n = 1'b0;
    #1;
    check("R10 valid cleared", word_valid, 0);
    check("R10 addr cleared", rd_addr, 0);
    tick();
    rst_n = 1'b1;
    tick();
    check("R10 idle after reset", word_valid, 0);

    finish_run();
  end

endmodule